// File: doc/BRIEF.md
# Conditional Branch Resolver

This block decides, once per cycle, where execution goes next. It receives a decoded branch request, the current flag word and the address of the current instruction. From these it works out whether the branch condition holds. It then registers the next instruction pointer: the taken target, or the address just past the current instruction. Conditional jumps take their target from an immediate field. Unconditional jumps take it from the immediate field or from a register.

The condition code is four bits wide. Fourteen codes select a flag predicate. The predicates cover equality, signed ordering (greater/less), unsigned ordering (above/below), overflow and carry. The two remaining codes mark unconditional jumps. Codes are laid out as complementary pairs: each odd code is the logical inverse of the even code below it. The evaluator therefore computes one base predicate per pair and inverts it with the low code bit.

The resolver sits between decode and fetch. Whatever it registers is the fetch address for the next cycle. Alongside the pointer it registers a taken indication.

Top module: `branch_resolver`

## Requirements
- R1: While `rst_n` is low, `next_ip` is zero and `taken` is low, one clock after the reset is sampled.
- R2: With `br_valid` low, the clock edge loads `next_ip` with `cur_ip + insn_len` and clears `taken`, whatever the code and flags.
- R3: Code 0 (equal) is satisfied when ZF = 1; code 1 (not equal) is satisfied when ZF = 0.
- R4: Signed codes: 2 (less-or-equal) when ZF = 1 or SF ≠ OF; 3 (greater) is its inverse; 4 (less) when SF ≠ OF; 5 (greater-or-equal) is its inverse.
- R5: Unsigned codes: 6 (below-or-equal) when CF = 1 or ZF = 1; 7 (above) is its inverse; 8 (below) when CF = 1; 9 (above-or-equal) is its inverse.
- R6: Codes 10 (overflow) and 11 (no overflow) test OF = 1 and OF = 0; codes 12 (carry) and 13 (no carry) test CF = 1 and CF = 0.
- R7: For codes 0 to 13 with `br_valid` high, a satisfied condition loads `tgt_direct` and sets `taken`; an unsatisfied one loads `cur_ip + insn_len` and clears `taken`.
- R8: Code 14 is an unconditional jump to `tgt_direct`, and `taken` is set regardless of flags.
- R9: Code 15 is an unconditional jump to `tgt_reg`, and `taken` is set regardless of flags.
- R10: The fall-through sum wraps modulo 2^ADDR_W.
- R11: Flag word bit positions are CF = 0, ZF = 6, SF = 7, OF = 11; every other flag bit has no effect on `next_ip` or `taken`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_valid | input | 1 | Current instruction is a branch |
| cond_code | input | 4 | Condition selector (see R3 to R9) |
| flag_word | input | 32 | Current status flags |
| tgt_direct | input | ADDR_W | Immediate branch target |
| tgt_reg | input | ADDR_W | Register-held branch target |
| insn_len | input | LEN_W | Length of the current instruction |
| cur_ip | input | ADDR_W | Address of the current instruction |
| next_ip | output | ADDR_W | Registered next instruction pointer |
| taken | output | 1 | Registered taken indication |

## Verification
All results go through one register stage. A request applied before a rising edge appears on `next_ip` and `taken` just after that edge. The bench changes inputs on the falling edge and waits for the next rising edge. It then samples at the following falling edge, half a period after the register has updated. Every scenario task uses this same one-edge latency. The bench runs every predicate code against all sixteen combinations of the four meaningful flags, with noise in the ignored bits.

// File: rtl/br_pkg.sv
package br_pkg;

  localparam int FLAG_W = 32;
  localparam int CF_BIT = 0;
  localparam int ZF_BIT = 6;
  localparam int SF_BIT = 7;
  localparam int OF_BIT = 11;

  typedef enum logic [3:0] {
    CC_EQ   = 4'd0,
    CC_NE   = 4'd1,
    CC_LE   = 4'd2,
    CC_G    = 4'd3,
    CC_L    = 4'd4,
    CC_GE   = 4'd5,
    CC_BE   = 4'd6,
    CC_A    = 4'd7,
    CC_B    = 4'd8,
    CC_AE   = 4'd9,
    CC_O    = 4'd10,
    CC_NO   = 4'd11,
    CC_C    = 4'd12,
    CC_NC   = 4'd13,
    CC_JMP  = 4'd14,
    CC_JMPR = 4'd15
  } cond_e;

  typedef struct packed {
    logic cf;
    logic zf;
    logic sf;
    logic of;
  } flags_t;

  // Base predicate for a complementary pair; pair index is code[3:1].
  function automatic logic pair_base(input logic [2:0] pair, input flags_t f);
    logic r;
    case (pair)
      3'd0:    r = f.zf;
      3'd1:    r = f.zf | (f.sf ^ f.of);
      3'd2:    r = f.sf ^ f.of;
      3'd3:    r = f.cf | f.zf;
      3'd4:    r = f.cf;
      3'd5:    r = f.of;
      3'd6:    r = f.cf;
      default: r = 1'b1;
    endcase
    return r;
  endfunction

  function automatic logic [63:0] add_len(input logic [63:0] ip, input logic [63:0] len);
    return ip + len;
  endfunction

endpackage

// File: rtl/br_flag_tap.sv
module br_flag_tap
  import br_pkg::*;
(
  input  logic [FLAG_W-1:0] flag_word,
  output flags_t            flags
);
  always_comb begin
    flags.cf = flag_word[CF_BIT];
    flags.zf = flag_word[ZF_BIT];
    flags.sf = flag_word[SF_BIT];
    flags.of = flag_word[OF_BIT];
  end
endmodule

// File: rtl/br_cond_eval.sv
module br_cond_eval
  import br_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] cond_code,
  input  flags_t     flags,
  output logic       cond_hit,
  output logic       is_uncond,
  output logic       use_reg
);
  logic base;
  logic invert;

  always_comb begin
    is_uncond = (cond_code == CC_JMP) || (cond_code == CC_JMPR);
    use_reg   = (cond_code == CC_JMPR);
    base      = pair_base(cond_code[3:1], flags);
    invert    = cond_code[0] & ~is_uncond;
    cond_hit  = is_uncond ? 1'b1 : (base ^ invert);
  end

  // R4: signed less must track SF != OF
  a_r4_less: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_code == CC_L) |-> (cond_hit == (flags.sf != flags.of)));

  // R5: above requires both CF and ZF clear
  a_r5_above: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_code == CC_A) |-> (cond_hit == (!flags.cf && !flags.zf)));
endmodule

// File: rtl/br_target_mux.sv
module br_target_mux #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 4
) (
  input  logic              br_valid,
  input  logic              cond_hit,
  input  logic              use_reg,
  input  logic [ADDR_W-1:0] tgt_direct,
  input  logic [ADDR_W-1:0] tgt_reg,
  input  logic [LEN_W-1:0]  insn_len,
  input  logic [ADDR_W-1:0] cur_ip,
  output logic [ADDR_W-1:0] fall_ip,
  output logic [ADDR_W-1:0] pick_ip,
  output logic              pick_taken
);
  logic [63:0] sum64;

  always_comb begin
    sum64      = br_pkg::add_len(64'(cur_ip), 64'(insn_len));
    fall_ip    = sum64[ADDR_W-1:0];
    pick_taken = br_valid & cond_hit;
    if (!pick_taken)  pick_ip = fall_ip;
    else if (use_reg) pick_ip = tgt_reg;
    else              pick_ip = tgt_direct;
  end
endmodule

// File: rtl/branch_resolver.sv
module branch_resolver
  import br_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              br_valid,
  input  logic [3:0]        cond_code,
  input  logic [31:0]       flag_word,
  input  logic [ADDR_W-1:0] tgt_direct,
  input  logic [ADDR_W-1:0] tgt_reg,
  input  logic [LEN_W-1:0]  insn_len,
  input  logic [ADDR_W-1:0] cur_ip,
  output logic [ADDR_W-1:0] next_ip,
  output logic              taken
);
  flags_t            flags;
  logic              cond_hit;
  logic              is_uncond;
  logic              use_reg;
  logic [ADDR_W-1:0] fall_ip;
  logic [ADDR_W-1:0] pick_ip;
  logic              pick_taken;

  br_flag_tap u_tap (
    .flag_word (flag_word),
    .flags     (flags)
  );

  br_cond_eval u_eval (
    .clk       (clk),
    .rst_n     (rst_n),
    .cond_code (cond_code),
    .flags     (flags),
    .cond_hit  (cond_hit),
    .is_uncond (is_uncond),
    .use_reg   (use_reg)
  );

  br_target_mux #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_mux (
    .br_valid   (br_valid),
    .cond_hit   (cond_hit),
    .use_reg    (use_reg),
    .tgt_direct (tgt_direct),
    .tgt_reg    (tgt_reg),
    .insn_len   (insn_len),
    .cur_ip     (cur_ip),
    .fall_ip    (fall_ip),
    .pick_ip    (pick_ip),
    .pick_taken (pick_taken)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      next_ip <= '0;
      taken   <= 1'b0;
    end else begin
      next_ip <= pick_ip;
      taken   <= pick_taken;
    end
  end

  // R1: reset clears pointer and taken
  a_r1_reset_zero: assert property (@(posedge clk)
    !rst_n |=> (next_ip == '0 && !taken));

  // R2: no branch means fall through, not taken
  a_r2_no_branch: assert property (@(posedge clk) disable iff (!rst_n)
    !br_valid |=> (!taken && next_ip == $past(fall_ip)));

  // R7: failed condition falls through
  a_r7_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && !cond_hit) |=> (!taken && next_ip == $past(fall_ip)));

  // R8: unconditional direct jump
  a_r8_jump_direct: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && cond_code == CC_JMP) |=> (taken && next_ip == $past(tgt_direct)));

  // R9: unconditional register jump
  a_r9_jump_reg: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && cond_code == CC_JMPR) |=> (taken && next_ip == $past(tgt_reg)));

  // R8/R9: unconditional codes always hit
  a_r8_uncond_hit: assert property (@(posedge clk) disable iff (!rst_n)
    is_uncond |-> cond_hit);
endmodule

// File: tb/tb_branch_resolver.sv
module tb_branch_resolver;
  localparam int AW = 32;
  localparam int LW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          br_valid;
  logic [3:0]    cond_code;
  logic [31:0]   flag_word;
  logic [AW-1:0] tgt_direct, tgt_reg, cur_ip;
  logic [LW-1:0] insn_len;
  logic [AW-1:0] next_ip;
  logic          taken;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  branch_resolver #(.ADDR_W(AW), .LEN_W(LW)) dut (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .cond_code(cond_code),
    .flag_word(flag_word), .tgt_direct(tgt_direct), .tgt_reg(tgt_reg),
    .insn_len(insn_len), .cur_ip(cur_ip), .next_ip(next_ip), .taken(taken)
  );

  function automatic logic [31:0] mk_flags(input logic cf, zf, sf, of, input logic [31:0] noise);
    logic [31:0] w;
    w = noise & ~32'h0000_08C1;
    w[0] = cf; w[6] = zf; w[7] = sf; w[11] = of;
    return w;
  endfunction

  function automatic logic ref_hit(input int code, input logic cf, zf, sf, of);
    case (code)
      0:  return zf;
      1:  return !zf;
      2:  return zf || (sf != of);
      3:  return !zf && (sf == of);
      4:  return sf != of;
      5:  return sf == of;
      6:  return cf || zf;
      7:  return !cf && !zf;
      8:  return cf;
      9:  return !cf;
      10: return of;
      11: return !of;
      12: return cf;
      13: return !cf;
      default: return 1'b1;
    endcase
  endfunction

  task automatic check(input string req, input logic [AW-1:0] exp_ip, input logic exp_tk);
    checks++;
    if (next_ip !== exp_ip || taken !== exp_tk) begin
      errors++;
      $display("FAIL %s next_ip=%h taken=%b expected next_ip=%h taken=%b",
               req, next_ip, taken, exp_ip, exp_tk);
    end
  endtask

  task automatic apply(input logic v, input logic [3:0] cc, input logic [31:0] fw,
                       input logic [AW-1:0] td, input logic [AW-1:0] tr,
                       input logic [LW-1:0] ln, input logic [AW-1:0] ip);
    @(negedge clk);
    br_valid = v; cond_code = cc; flag_word = fw;
    tgt_direct = td; tgt_reg = tr; insn_len = ln; cur_ip = ip;
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    br_valid = 1'b1; cond_code = 4'd14; flag_word = '1;
    tgt_direct = 32'h1234_5678; tgt_reg = 32'h0; insn_len = 4'd3; cur_ip = 32'h100;
    @(negedge clk);
    check("R1", '0, 1'b0);
    @(negedge clk);
    check("R1", '0, 1'b0);
    rst_n = 1'b1;
  endtask

  task automatic t_no_branch();
    for (int c = 0; c < 16; c++) begin
      apply(1'b0, 4'(c), 32'hFFFF_FFFF, 32'hAAAA_0000, 32'hBBBB_0000, 4'd5, 32'h0000_2000 + 32'(c));
      check("R2", 32'h0000_2005 + 32'(c), 1'b0);
    end
  endtask

  task automatic t_conditions();
    for (int c = 0; c < 14; c++) begin
      for (int f = 0; f < 16; f++) begin
        logic cf, zf, sf, of, hit;
        logic [AW-1:0] ip, td;
        string req;
        cf = f[0]; zf = f[1]; sf = f[2]; of = f[3];
        hit = ref_hit(c, cf, zf, sf, of);
        ip = 32'h0040_0000 + 32'(c * 64 + f * 4);
        td = 32'h0080_0000 + 32'(c * 16 + f);
        if (c < 2)       req = "R3/R7";
        else if (c < 6)  req = "R4/R7";
        else if (c < 10) req = "R5/R7";
        else             req = "R6/R7";
        apply(1'b1, 4'(c), mk_flags(cf, zf, sf, of, 32'(f) * 32'h1357_9BDF),
              td, 32'hDEAD_0000, 4'(f % 15 + 1), ip);
        check(req, hit ? td : ip + 32'(f % 15 + 1), hit);
      end
    end
  endtask

  task automatic t_uncond();
    for (int f = 0; f < 16; f += 5) begin
      apply(1'b1, 4'd14, mk_flags(f[0], f[1], f[2], f[3], 32'h0), 32'hCAFE_0010, 32'hBEEF_0020, 4'd2, 32'h500);
      check("R8", 32'hCAFE_0010, 1'b1);
      apply(1'b1, 4'd15, mk_flags(f[0], f[1], f[2], f[3], 32'h0), 32'hCAFE_0010, 32'hBEEF_0020, 4'd2, 32'h500);
      check("R9", 32'hBEEF_0020, 1'b1);
    end
  endtask

  task automatic t_wrap();
    apply(1'b0, 4'd0, 32'h0, 32'h0, 32'h0, 4'd6, 32'hFFFF_FFFC);
    check("R10", 32'h0000_0002, 1'b0);
    apply(1'b1, 4'd1, mk_flags(1'b0, 1'b1, 1'b0, 1'b0, 32'h0), 32'h77, 32'h0, 4'd15, 32'hFFFF_FFFF);
    check("R10", 32'h0000_000E, 1'b0);
  endtask

  task automatic t_ignored_bits();
    // R11: all ignored bits set, meaningful flags clear: EQ must not hit, NC must hit
    apply(1'b1, 4'd0, 32'hFFFF_F73E, 32'h900, 32'h0, 4'd1, 32'h40);
    check("R11", 32'h41, 1'b0);
    apply(1'b1, 4'd13, 32'hFFFF_F73E, 32'h900, 32'h0, 4'd1, 32'h40);
    check("R11", 32'h900, 1'b1);
    apply(1'b1, 4'd10, 32'hFFFF_F73E, 32'h900, 32'h0, 4'd1, 32'h40);
    check("R11", 32'h41, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0;
    br_valid = 1'b0; cond_code = '0; flag_word = '0;
    tgt_direct = '0; tgt_reg = '0; insn_len = '0; cur_ip = '0;
    t_reset();
    t_no_branch();
    t_conditions();
    t_uncond();
    t_wrap();
    t_ignored_bits();
    t_reset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule